// File: doc/BRIEF.md
# Serial Master Clock Rate Generator

This block produces the serial clock for a serial master port that runs either in a two-wire (I2C-style) mode or in a four-wire (SPI-style) mode. A software-set reload value fixes the rate. The internal counter advances once every two system clocks. Each time it counts down from the reload value to zero, one half-period of the serial clock has passed. The serial clock then flips and the counter reloads. With the default settings, the serial clock frequency is the system clock divided by four times (reload + 1).

The generator has no separate enable. A write strobe to the transmit buffer starts it. It keeps running until the transfer-done indication arrives, then stops and holds the serial clock at whatever level it had. A one-cycle pulse marks every half-period boundary, so shift logic can sample or shift on it. In two-wire mode, reload values below 3 cannot be used. Such a value is raised to 3 and a sticky error flag is set.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset, and until the first start, the serial clock sits at its idle level: high when the mode input is 1 (two-wire), and equal to the polarity input when the mode input is 0 (four-wire). The half-period pulse and the error flag are 0.
- R2: Without a buffer write, the serial clock never toggles and no half-period pulse appears.
- R3: A buffer write sampled at a clock edge starts the generator. The first serial clock toggle happens 2*(reload+1) edges later. Every following toggle comes another 2*(reload+1) edges after the previous one.
- R4: The half-period pulse is high for exactly one cycle, and it is high in exactly those cycles in which the serial clock has just changed level.
- R5: A transfer-done indication stops the generator. No further toggle or pulse occurs, and the serial clock holds its last level.
- R6: In two-wire mode, a reload value of 0, 1 or 2 behaves as 3, giving a half-period of 8 cycles.
- R7: In four-wire mode, any reload value is used as given; a reload of 0 gives a half-period of 2 cycles, and the error flag stays 0.
- R8: Loading a reload value below 3 in two-wire mode sets the error flag. The flag stays set until reset.
- R9: A buffer write that arrives while the generator runs is ignored and does not shift the toggle timing.
- R10: If transfer-done and a buffer write arrive in the same cycle while idle, the generator stays stopped.
- R11: The reload value is read again at every half-period boundary. A change made during a half-period takes effect for the half-period after the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| reload_i | input | 8 | Countdown reload value |
| mode_i | input | 1 | 1 = two-wire mode, 0 = four-wire mode |
| cpol_i | input | 1 | Idle clock level in four-wire mode |
| buf_wr_i | input | 1 | Transmit buffer write strobe; starts the generator |
| xfer_done_i | input | 1 | Transfer complete; stops the generator |
| sclk_o | output | 1 | Serial clock |
| half_pulse_o | output | 1 | One-cycle pulse at each half-period boundary |
| clamp_err_o | output | 1 | Sticky flag: a reload value was raised in two-wire mode |

## Verification
The hardest case to reach is R11, a reload change that must land between two half-period boundaries. The bench waits for a half-period pulse, changes the reload value on the following falling edge, and then measures two intervals: the first must still use the old value, because the counter was loaded at that boundary, and the second must use the new one. A second hard case is a buffer write in the middle of a countdown. The bench places it a few cycles after start and checks that the first toggle still arrives on the original cycle.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

   typedef enum logic {
      SCLK_MODE_4W = 1'b0,
      SCLK_MODE_2W = 1'b1
   } sclk_mode_e;

   function automatic logic idle_level(input sclk_mode_e mode, input logic cpol);
      return (mode == SCLK_MODE_2W) ? 1'b1 : cpol;
   endfunction

endpackage

// File: rtl/sclk_tick_gen.sv
module sclk_tick_gen #(
   parameter int PRESCALE = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);
   localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
   localparam logic [PW-1:0] ONE  = PW'(1);

   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick_o = run_i;
      end else begin : g_divided
         logic [PW-1:0] phase_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               phase_q <= '0;
            end else if (restart_i) begin
               phase_q <= '0;
            end else if (run_i) begin
               if (phase_q == LAST) phase_q <= '0;
               else                 phase_q <= phase_q + ONE;
            end
         end
         assign tick_o = run_i && (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/sclk_reload_guard.sv
module sclk_reload_guard
   import sclk_pkg::*;
#(
   parameter int RELOAD_W = 8,
   parameter int MIN_2W   = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [RELOAD_W-1:0] raw_i,
   input  sclk_mode_e          mode_i,
   input  logic                load_i,
   output logic [RELOAD_W-1:0] eff_o,
   output logic                err_o
);
   localparam logic [RELOAD_W-1:0] MIN_V = RELOAD_W'(MIN_2W);

   logic too_low;

   generate
      if (MIN_2W == 0) begin : g_no_clamp
         assign too_low = 1'b0;
      end else begin : g_clamp
         assign too_low = (mode_i == SCLK_MODE_2W) && (raw_i < MIN_V);
      end
   endgenerate

   assign eff_o = too_low ? MIN_V : raw_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                err_o <= 1'b0;
      else if (load_i && too_low) err_o <= 1'b1;
   end
endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter #(
   parameter int RELOAD_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic                stop_i,
   input  logic                tick_i,
   input  logic [RELOAD_W-1:0] eff_i,
   input  logic                idle_i,
   output logic                sclk_o,
   output logic                pulse_o,
   output logic                run_o,
   output logic                started_o,
   output logic                load_o
);
   localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

   logic [RELOAD_W-1:0] cnt_q;
   logic                sclk_q;
   logic                at_zero;

   assign at_zero = (cnt_q == '0);
   assign load_o  = !stop_i && (start_i || (tick_i && at_zero));
   assign sclk_o  = started_o ? sclk_q : idle_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_o     <= 1'b0;
         started_o <= 1'b0;
         cnt_q     <= '0;
         sclk_q    <= 1'b0;
         pulse_o   <= 1'b0;
      end else begin
         pulse_o <= 1'b0;
         if (stop_i) begin
            run_o <= 1'b0;
         end else if (start_i) begin
            run_o     <= 1'b1;
            started_o <= 1'b1;
            cnt_q     <= eff_i;
            if (!started_o) sclk_q <= idle_i;
         end else if (tick_i) begin
            if (at_zero) begin
               sclk_q  <= ~sclk_q;
               cnt_q   <= eff_i;
               pulse_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
   import sclk_pkg::*;
#(
   parameter int RELOAD_W = 8,
   parameter int PRESCALE = 2,
   parameter int MIN_2W   = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [RELOAD_W-1:0] reload_i,
   input  logic                mode_i,
   input  logic                cpol_i,
   input  logic                buf_wr_i,
   input  logic                xfer_done_i,
   output logic                sclk_o,
   output logic                half_pulse_o,
   output logic                clamp_err_o
);
   generate
      if (RELOAD_W < 2) begin : g_bad_width
         $fatal(1, "RELOAD_W must be at least 2");
      end
      if (PRESCALE < 1) begin : g_bad_prescale
         $fatal(1, "PRESCALE must be at least 1");
      end
      if (MIN_2W < 0 || MIN_2W >= (1 << RELOAD_W)) begin : g_bad_min
         $fatal(1, "MIN_2W must fit in RELOAD_W bits");
      end
   endgenerate

   sclk_mode_e          mode;
   logic                idle_lvl;
   logic                run_w;
   logic                started_w;
   logic                start_w;
   logic                tick_w;
   logic                load_w;
   logic [RELOAD_W-1:0] eff_w;

   assign mode     = sclk_mode_e'(mode_i);
   assign idle_lvl = idle_level(mode, cpol_i);
   assign start_w  = buf_wr_i && !run_w && !xfer_done_i;

   sclk_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_w),
      .restart_i (start_w),
      .tick_o    (tick_w)
   );

   sclk_reload_guard #(.RELOAD_W(RELOAD_W), .MIN_2W(MIN_2W)) u_guard (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (reload_i),
      .mode_i (mode),
      .load_i (load_w),
      .eff_o  (eff_w),
      .err_o  (clamp_err_o)
   );

   sclk_half_counter #(.RELOAD_W(RELOAD_W)) u_half (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_w),
      .stop_i    (xfer_done_i),
      .tick_i    (tick_w),
      .eff_i     (eff_w),
      .idle_i    (idle_lvl),
      .sclk_o    (sclk_o),
      .pulse_o   (half_pulse_o),
      .run_o     (run_w),
      .started_o (started_w),
      .load_o    (load_w)
   );
endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk #(
   parameter int RELOAD_W = 8,
   parameter int MIN_2W   = 3
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                mode_i,
   input logic                buf_wr_i,
   input logic                xfer_done_i,
   input logic                sclk_o,
   input logic                half_pulse_o,
   input logic                clamp_err_o,
   input logic                run_w,
   input logic                started_w,
   input logic [RELOAD_W-1:0] eff_w
);
   localparam logic [RELOAD_W-1:0] MIN_V = RELOAD_W'(MIN_2W);

   // R4: the pulse lasts one cycle
   assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      half_pulse_o |=> !half_pulse_o);

   // R4: a pulse marks a serial clock level change
   assert_pulse_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (half_pulse_o && $past(started_w)) |-> (sclk_o != $past(sclk_o)));

   // R4: once started, the serial clock changes only together with a pulse
   assert_edge_has_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(started_w) && !$stable(sclk_o)) |-> half_pulse_o);

   // R5: done stops the generator
   assert_done_stops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      xfer_done_i |=> !run_w);

   // R10: done wins over a simultaneous write
   assert_done_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer_done_i && buf_wr_i && !run_w) |=> !run_w);

   // R6: the two-wire reload never drops below the minimum
   assert_min_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_i |-> (eff_w >= MIN_V));

   // R8: the error flag is sticky
   assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clamp_err_o |=> clamp_err_o);

   // R2: no pulse before the first start
   assert_quiet_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !started_w |-> !half_pulse_o);
endmodule

bind sclk_rate_gen sclk_rate_gen_chk #(.RELOAD_W(RELOAD_W), .MIN_2W(MIN_2W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .mode_i       (mode_i),
   .buf_wr_i     (buf_wr_i),
   .xfer_done_i  (xfer_done_i),
   .sclk_o       (sclk_o),
   .half_pulse_o (half_pulse_o),
   .clamp_err_o  (clamp_err_o),
   .run_w        (run_w),
   .started_w    (started_w),
   .eff_w        (eff_w)
);

// File: tb/sclk_rate_gen_tb.sv
module sclk_rate_gen_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;
   localparam int NVEC       = 5;
   // {mode, cpol, reload, expected half-period in cycles, expected error flag}
   localparam logic [18:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 8'h13, 8'd40, 1'b0},
      {1'b1, 1'b0, 8'h01, 8'd8,  1'b1},
      {1'b1, 1'b0, 8'h03, 8'd8,  1'b0},
      {1'b0, 1'b1, 8'h00, 8'd2,  1'b0},
      {1'b0, 1'b0, 8'h09, 8'd20, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] reload = 8'h00;
   logic       mode = 1'b1;
   logic       cpol = 1'b0;
   logic       buf_wr = 1'b0;
   logic       done = 1'b0;
   logic       sclk, pulse, err;
   int         total = 0;
   int         bad = 0;
   int         cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sclk_rate_gen u_dut (
      .clk_i(clk), .rst_ni(rst_n), .reload_i(reload), .mode_i(mode),
      .cpol_i(cpol), .buf_wr_i(buf_wr), .xfer_done_i(done),
      .sclk_o(sclk), .half_pulse_o(pulse), .clamp_err_o(err)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic m, input logic p, input logic [7:0] r);
      @(negedge clk);
      rst_n = 1'b0; mode = m; cpol = p; reload = r; buf_wr = 1'b0; done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic start();
      buf_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      buf_wr = 1'b0;
   endtask

   // counts edges until the pulse is seen at a falling edge; 0 when none within limit
   task automatic wait_pulse(input int limit, output int n);
      n = 0;
      for (int i = 1; i <= limit; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (pulse) begin
            n = i;
            break;
         end
      end
   endtask

   task automatic stop();
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
   endtask

   initial begin
      int n;
      int pulses;
      logic idle, lvl;

      // table walk: R1, R3, R4, R6, R7, R8
      for (int v = 0; v < NVEC; v++) begin
         do_reset(VEC[v][18], VEC[v][17], VEC[v][16:9]);
         @(negedge clk);
         idle = VEC[v][18] ? 1'b1 : VEC[v][17];
         chk("R1 idle level", sclk, idle);
         chk("R1 pulse low", pulse, 0);
         chk("R1 error low", err, 0);
         start();
         wait_pulse(600, n);
         chk("R3 first half-period", n, VEC[v][8:1]);
         chk("R4 level after first pulse", sclk, !idle);
         wait_pulse(600, n);
         chk("R3 second half-period", n, VEC[v][8:1]);
         chk("R4 level after second pulse", sclk, idle);
         chk(VEC[v][0] ? "R8 error set" : "R7 error clear", err, VEC[v][0]);
         stop();
      end

      // R8: the flag survives a valid reload and a stop, and reset clears it
      do_reset(1'b1, 1'b0, 8'h02);
      start();
      @(negedge clk);
      reload = 8'h20;
      repeat (20) @(negedge clk);
      stop();
      repeat (10) @(negedge clk);
      chk("R8 sticky error", err, 1);
      do_reset(1'b1, 1'b0, 8'h20);
      @(negedge clk);
      chk("R8 error cleared by reset", err, 0);

      // R1 / R2: SPI idle follows polarity, nothing moves without a write
      do_reset(1'b0, 1'b0, 8'h04);
      @(negedge clk);
      chk("R1 idle follows cpol=0", sclk, 0);
      cpol = 1'b1;
      @(negedge clk);
      chk("R1 idle follows cpol=1", sclk, 1);
      wait_pulse(40, n);
      chk("R2 no pulse without write", n, 0);
      chk("R2 clock still idle", sclk, 1);

      // R5: stop holds the level
      do_reset(1'b0, 1'b0, 8'h02);
      start();
      wait_pulse(100, n);
      chk("R5 running first half", n, 6);
      lvl = sclk;
      stop();
      wait_pulse(60, n);
      chk("R5 no pulse after done", n, 0);
      chk("R5 level held", sclk, lvl);

      // R9: a second write during the countdown is ignored
      do_reset(1'b0, 1'b0, 8'h05);
      buf_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      buf_wr = 1'b0;
      repeat (2) @(negedge clk);
      buf_wr = 1'b1;
      @(negedge clk);
      buf_wr = 1'b0;
      pulses = 3;
      wait_pulse(100, n);
      chk("R9 timing unchanged", n + pulses, 12);
      stop();

      // R10: done and write together while idle
      do_reset(1'b0, 1'b0, 8'h01);
      buf_wr = 1'b1;
      done = 1'b1;
      @(negedge clk);
      buf_wr = 1'b0;
      done = 1'b0;
      wait_pulse(40, n);
      chk("R10 no start", n, 0);
      chk("R10 clock idle", sclk, 0);

      // R11: reload change applies after the next boundary
      do_reset(1'b0, 1'b0, 8'h05);
      start();
      wait_pulse(100, n);
      chk("R11 initial half", n, 12);
      reload = 8'h01;
      wait_pulse(100, n);
      chk("R11 old value still used", n, 12);
      wait_pulse(100, n);
      chk("R11 new value used", n, 4);
      stop();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule